// File: doc/BRIEF.md
# Queued SPI Master

This block is an SPI master that works through a list of transfers held in its own queue, so a processor sets up a batch once and the transfers then run on their own. Each queue entry carries a chip-select index, a bit count, a pause that follows the transfer, and a transmit word. While it works through the list, the engine writes the word it receives back into the receive slot of that same entry. The processor reads the receive slot back through a separate read port.

The processor fills entries through a write port. It then chooses the first and last entry to run and pulses `go`. The engine runs entries in ascending order from the first pointer to the last. It then stops and raises `done`. If `wrap_en` is high, it goes back to the first pointer instead and keeps running until `halt` is pulsed. The serial clock idles low. Data leaves most significant bit first, changes on the falling edge and is sampled on the rising edge. The serial clock period is `clk_div` system cycles.

Top module: `qspi_queue_master`

## Requirements
- R1: After a synchronous active-low reset, `cs_n` is all ones, `sclk` is 0, `busy` and `done` are 0 and every receive slot reads 0. While the engine is idle, `cs_n` stays all ones and `sclk` stays 0.
- R2: `sclk` idles low. `mosi` only changes while `sclk` is low. The engine samples `miso` at the same system edge that raises `sclk`.
- R3: An entry with length code n (4 bits, 0..15) sends exactly n+1 serial clock pulses. The bits sent are tx[n] down to tx[0] of the entry's transmit word, and tx bits above n are never sent.
- R4: When an entry ends, its receive slot holds the n+1 received bits in bits [n:0], with the first received bit at position n. Bits above n read 0.
- R5: An entry with chip-select index k (2 bits) drives `cs_n[k]` low for its whole transfer. At most one `cs_n` bit is ever low.
- R6: Each serial clock half-period lasts `clk_div`/2 system cycles, where `clk_div` is even and at least 2. Chip select goes low one half-period before the first rising edge. It goes high one half-period after the last falling edge.
- R7: After an entry with delay count d (8 bits), `cs_n` stays all ones for 2·d·(`clk_div`/2)+1 system cycles before the next entry's chip select goes low.
- R8: A pulse on `go` while idle runs the entries from `start_ptr` up to `end_ptr` in ascending order. With `wrap_en` low, `busy` falls and `done` rises once the `end_ptr` entry and its delay have finished.
- R9: With `wrap_en` high, the entry at `start_ptr` follows the `end_ptr` entry, and transfers continue until a halt.
- R10: A `halt` pulse lets the current entry and its delay finish. The engine then stops with `busy` low and `done` low.
- R11: While busy, a write to the entry currently running is ignored. A write to any other entry takes effect, including on later passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| q_we | input | 1 | Queue entry write strobe |
| q_addr | input | AW | Entry to write |
| q_cs | input | CSW | Chip-select index for the entry |
| q_len | input | LW | Length code (bits minus one) |
| q_dly | input | DLYW | Post-transfer delay in serial clock periods |
| q_tx | input | DW | Transmit word |
| rd_addr | input | AW | Entry whose receive slot is read |
| rd_rx | output | DW | Receive slot of `rd_addr` |
| start_ptr | input | AW | First entry of the run |
| end_ptr | input | AW | Last entry of the run |
| wrap_en | input | 1 | Restart at `start_ptr` after `end_ptr` |
| go | input | 1 | Start pulse, honoured when idle |
| halt | input | 1 | Stop at the next entry boundary |
| clk_div | input | DIVW | Serial clock divisor, even, at least 2 |
| busy | output | 1 | Engine running |
| done | output | 1 | Queue completed without halt |
| cur_ptr | output | AW | Entry being executed |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |

## Verification
If the bit counter or the shift register went wrong, the very next transfer would show the wrong number of `sclk` pulses or wrong `mosi` bits. The matching receive slot would also be wrong as soon as that entry completes. A pointer or wrap fault would show up at the following entry boundary as the wrong `cs_n` line or the wrong word. A lock fault would show up one pass later, as a changed word on an entry that should have kept its old contents. A timing fault in the divider or the delay counter shows up within one half-period or one gap, as a lead time or a chip-select gap of the wrong length.

// File: rtl/qspi_pkg.sv
// Shared types for the queued SPI master.
// Assumes: nothing beyond the IEEE 1800-2017 enum semantics.
package qspi_pkg;
    // Sequencer phases: load entry, serial low/high halves, tail half, gap.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_GAP
    } seq_st_t;
endpackage

// File: rtl/qspi_queue.sv
// Entry storage: configuration written by the host and receive slots
// written by the engine. Host writes to the locked entry are dropped.
// Assumes: the engine writes only the entry at eng_addr.
module qspi_queue #(
    parameter int DEPTH = 8,
    parameter int AW    = 3,
    parameter int CSW   = 2,
    parameter int LW    = 4,
    parameter int DLYW  = 8,
    parameter int DW    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  logic [CSW-1:0]  host_cs,
    input  logic [LW-1:0]   host_len,
    input  logic [DLYW-1:0] host_dly,
    input  logic [DW-1:0]   host_tx,
    input  logic            lock,
    input  logic [AW-1:0]   eng_addr,
    input  logic            rx_we,
    input  logic [DW-1:0]   rx_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [CSW-1:0]  eng_cs,
    output logic [LW-1:0]   eng_len,
    output logic [DLYW-1:0] eng_dly,
    output logic [DW-1:0]   eng_tx,
    output logic [DW-1:0]   rd_rx
);
    logic [CSW-1:0]  cs_m  [DEPTH];
    logic [LW-1:0]   len_m [DEPTH];
    logic [DLYW-1:0] dly_m [DEPTH];
    logic [DW-1:0]   tx_m  [DEPTH];
    logic [DW-1:0]   rx_m  [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Host configuration write, blocked for the entry in flight.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cs_m[i]  <= '0;
                len_m[i] <= '0;
                dly_m[i] <= '0;
                tx_m[i]  <= '0;
            end else if (host_we && host_addr == AW'(i)
                         && !(lock && eng_addr == AW'(i))) begin
                cs_m[i]  <= host_cs;
                len_m[i] <= host_len;
                dly_m[i] <= host_dly;
                tx_m[i]  <= host_tx;
            end
        end

        // Engine write-back of the received word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rx_m[i] <= '0;
            else if (rx_we && eng_addr == AW'(i))
                rx_m[i] <= rx_data;
        end
    end

    assign eng_cs  = cs_m[eng_addr];
    assign eng_len = len_m[eng_addr];
    assign eng_dly = dly_m[eng_addr];
    assign eng_tx  = tx_m[eng_addr];
    assign rd_rx   = rx_m[rd_addr];

    // R11
    locked_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock) && eng_addr == $past(eng_addr))
        |-> ($stable(eng_tx) && $stable(eng_len) && $stable(eng_cs)));
endmodule

// File: rtl/qspi_halftick.sv
// Half-period timer: pulses tick every clk_div/2 cycles while run is high.
// It restarts from zero whenever run is low.
// Assumes: clk_div is even and at least 2.
module qspi_halftick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] clk_div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;
    logic [DIVW-1:0] half_m1;

    assign half_m1 = (clk_div >> 1) - DIVW'(1);
    assign tick    = run && (cnt == half_m1);

    // Count system cycles inside the current half-period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick)
            cnt <= '0;
        else
            cnt <= cnt + DIVW'(1);
    end

    // R6
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_m1 != '0) |=> !tick);
endmodule

// File: rtl/qspi_shifter.sv
// Serial shifter for SPI mode 0: presents the transmit MSB on mosi and
// collects miso bits into the low end of a receive word.
// Assumes: load comes before any shift or sample of a transfer.
module qspi_shifter #(
    parameter int DW = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] tx_word,
    input  logic [LW-1:0] len,
    input  logic          shift,
    input  logic          sample,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_word
);
    localparam logic [LW-1:0] TOP = LW'(DW - 1);

    logic [DW-1:0] tx_sh;

    // Transmit register: left-justify the active bits, move one per fall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sh <= '0;
        else if (load)
            tx_sh <= tx_word << (TOP - len);
        else if (shift)
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
    end

    // Receive register: clear at load, append one bit per rise.
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            rx_word <= '0;
        else if (sample)
            rx_word <= {rx_word[DW-2:0], miso};
    end

    assign mosi = tx_sh[DW-1];
endmodule

// File: rtl/qspi_queue_master.sv
// Queued SPI master top: the sequencer walks the entries from start_ptr to
// end_ptr, wrapping when asked, and drives the chip selects and serial clock.
// Assumes: clk_div is even and at least 2, and pointers stay constant
// while busy.
module qspi_queue_master #(
    parameter int DEPTH = 8,
    parameter int DW    = 16,
    parameter int NCS   = 4,
    parameter int DLYW  = 8,
    parameter int DIVW  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CSW  = $clog2(NCS),
    localparam int LW   = $clog2(DW)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            q_we,
    input  logic [AW-1:0]   q_addr,
    input  logic [CSW-1:0]  q_cs,
    input  logic [LW-1:0]   q_len,
    input  logic [DLYW-1:0] q_dly,
    input  logic [DW-1:0]   q_tx,
    input  logic [AW-1:0]   rd_addr,
    output logic [DW-1:0]   rd_rx,
    input  logic [AW-1:0]   start_ptr,
    input  logic [AW-1:0]   end_ptr,
    input  logic            wrap_en,
    input  logic            go,
    input  logic            halt,
    input  logic [DIVW-1:0] clk_div,
    output logic            busy,
    output logic            done,
    output logic [AW-1:0]   cur_ptr,
    output logic            sclk,
    output logic            mosi,
    input  logic            miso,
    output logic [NCS-1:0]  cs_n
);
    import qspi_pkg::*;

    seq_st_t         state;
    logic            tick;
    logic            halt_pend;
    logic [LW-1:0]   bits_left;
    logic [DLYW-1:0] dly_r;
    logic [DLYW:0]   gap_cnt;
    logic [CSW-1:0]  eng_cs;
    logic [LW-1:0]   eng_len;
    logic [DLYW-1:0] eng_dly;
    logic [DW-1:0]   eng_tx;
    logic [DW-1:0]   rx_word;
    logic            do_shift, do_sample, do_load, rx_we;
    logic            boundary, stop_now;

    assign busy      = (state != ST_IDLE);
    assign do_load   = (state == ST_LOAD);
    assign do_sample = (state == ST_LOW) && tick;
    assign do_shift  = (state == ST_HIGH) && tick && (bits_left != '0);
    assign rx_we     = (state == ST_TAIL) && tick;
    assign boundary  = (rx_we && dly_r == '0)
                     || ((state == ST_GAP) && tick && gap_cnt == (DLYW+1)'(1));
    assign stop_now  = halt_pend || halt || (cur_ptr == end_ptr && !wrap_en);

    qspi_queue #(
        .DEPTH(DEPTH), .AW(AW), .CSW(CSW), .LW(LW), .DLYW(DLYW), .DW(DW)
    ) i_queue (
        .clk(clk), .rst_n(rst_n),
        .host_we(q_we), .host_addr(q_addr), .host_cs(q_cs),
        .host_len(q_len), .host_dly(q_dly), .host_tx(q_tx),
        .lock(busy), .eng_addr(cur_ptr),
        .rx_we(rx_we), .rx_data(rx_word), .rd_addr(rd_addr),
        .eng_cs(eng_cs), .eng_len(eng_len), .eng_dly(eng_dly),
        .eng_tx(eng_tx), .rd_rx(rd_rx)
    );

    qspi_halftick #(.DIVW(DIVW)) i_halftick (
        .clk(clk), .rst_n(rst_n),
        .run(busy && !do_load), .clk_div(clk_div), .tick(tick)
    );

    qspi_shifter #(.DW(DW), .LW(LW)) i_shifter (
        .clk(clk), .rst_n(rst_n), .load(do_load), .tx_word(eng_tx),
        .len(eng_len), .shift(do_shift), .sample(do_sample),
        .miso(miso), .mosi(mosi), .rx_word(rx_word)
    );

    // Remember a halt request until the next entry boundary.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy)
            halt_pend <= 1'b0;
        else if (halt)
            halt_pend <= 1'b1;
    end

    // Sequencer: entry loading, serial phases, gap and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cur_ptr   <= '0;
            done      <= 1'b0;
            sclk      <= 1'b0;
            cs_n      <= '1;
            bits_left <= '0;
            dly_r     <= '0;
            gap_cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (go) begin
                    cur_ptr <= start_ptr;
                    done    <= 1'b0;
                    state   <= ST_LOAD;
                end
                ST_LOAD: begin
                    cs_n      <= ~(NCS'(1) << eng_cs);
                    bits_left <= eng_len;
                    dly_r     <= eng_dly;
                    state     <= ST_LOW;
                end
                ST_LOW: if (tick) begin
                    sclk  <= 1'b1;
                    state <= ST_HIGH;
                end
                ST_HIGH: if (tick) begin
                    sclk <= 1'b0;
                    if (bits_left == '0) begin
                        state <= ST_TAIL;
                    end else begin
                        bits_left <= bits_left - LW'(1);
                        state     <= ST_LOW;
                    end
                end
                ST_TAIL: if (tick) begin
                    cs_n    <= '1;
                    gap_cnt <= {dly_r, 1'b0};
                    if (dly_r != '0)
                        state <= ST_GAP;
                end
                ST_GAP: if (tick && !boundary)
                    gap_cnt <= gap_cnt - (DLYW+1)'(1);
                default: state <= ST_IDLE;
            endcase

            if (boundary) begin
                if (stop_now) begin
                    state <= ST_IDLE;
                    done  <= !(halt_pend || halt);
                end else begin
                    cur_ptr <= (cur_ptr == end_ptr) ? start_ptr
                                                    : cur_ptr + AW'(1);
                    state   <= ST_LOAD;
                end
            end
        end
    end

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs_n == '1 && !sclk));
    // R5
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));
    // R6
    sclk_in_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (cs_n != '1));
    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_qspi_queue_master.sv
`timescale 1ns/1ps
module test_qspi_queue_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        q_we = 1'b0;
    logic [2:0]  q_addr = '0;
    logic [1:0]  q_cs = '0;
    logic [3:0]  q_len = '0;
    logic [7:0]  q_dly = '0;
    logic [15:0] q_tx = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_rx;
    logic [2:0]  start_ptr = '0;
    logic [2:0]  end_ptr = '0;
    logic        wrap_en = 1'b0;
    logic        go = 1'b0;
    logic        halt = 1'b0;
    logic [7:0]  clk_div = 8'd4;
    logic        busy, done, sclk, mosi, miso;
    logic [2:0]  cur_ptr;
    logic [3:0]  cs_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Bench slave answers with the inverse of the bit it receives.
    assign miso = (cs_n != 4'hF) ? ~mosi : 1'b0;

    qspi_queue_master i_qspi_queue_master (
        .clk(clk), .rst_n(rst_n), .q_we(q_we), .q_addr(q_addr),
        .q_cs(q_cs), .q_len(q_len), .q_dly(q_dly), .q_tx(q_tx),
        .rd_addr(rd_addr), .rd_rx(rd_rx), .start_ptr(start_ptr),
        .end_ptr(end_ptr), .wrap_en(wrap_en), .go(go), .halt(halt),
        .clk_div(clk_div), .busy(busy), .done(done), .cur_ptr(cur_ptr),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    // Vectors: {cs index, length code, delay, transmit word}.
    localparam logic [29:0] VEC [0:5] = '{
        {2'd0, 4'd7,  8'd0, 16'h00A5},
        {2'd1, 4'd15, 8'd2, 16'hC3E1},
        {2'd2, 4'd0,  8'd1, 16'hFFF3},
        {2'd3, 4'd11, 8'd0, 16'h0ABC},
        {2'd1, 4'd4,  8'd3, 16'h1234},
        {2'd0, 4'd15, 8'd0, 16'h8001}
    };

    // ---------------- serial monitor ----------------
    logic        mon_clr = 1'b0;
    int          mon_n;
    logic        act, psclk, inlead;
    logic [15:0] mbits;
    int          mnb, mlead, gapc, pgap, mcs;
    int          rec_cs [16];
    int          rec_nb [16];
    int          rec_lead [16];
    int          rec_gap [16];
    logic [15:0] rec_bits [16];
    logic        cs_act;
    int          cs_idx;

    assign cs_act = (cs_n != 4'hF);
    always_comb begin
        cs_idx = -1;
        for (int i = 0; i < 4; i++)
            if (!cs_n[i]) cs_idx = i;
    end

    // Record each transfer: select line, bits, lead time and preceding gap.
    always @(negedge clk) begin
        if (mon_clr) begin
            mon_n <= 0; act <= 1'b0; psclk <= 1'b0; gapc <= 0;
            inlead <= 1'b0; mnb <= 0; mlead <= 0; mbits <= '0;
            pgap <= 0; mcs <= 0;
        end else begin
            if (cs_act && !act) begin
                mcs <= cs_idx; mbits <= '0; mnb <= 0; mlead <= 1;
                inlead <= 1'b1; pgap <= gapc;
            end else if (cs_act) begin
                if (!sclk && inlead) mlead <= mlead + 1;
                if (sclk && !psclk) begin
                    mbits <= {mbits[14:0], mosi};
                    mnb <= mnb + 1;
                    inlead <= 1'b0;
                end
            end
            if (!cs_act && act) begin
                if (mon_n < 16) begin
                    rec_cs[mon_n] <= mcs; rec_nb[mon_n] <= mnb;
                    rec_lead[mon_n] <= mlead; rec_gap[mon_n] <= pgap;
                    rec_bits[mon_n] <= mbits;
                end
                mon_n <= mon_n + 1;
                gapc <= 1;
            end else if (!cs_act) begin
                gapc <= gapc + 1;
            end
            act <= cs_act;
            psclk <= sclk;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req,
                       input logic [31:0] actv, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, actv, expv);
        end
    endtask

    function automatic logic [15:0] lmask(input logic [3:0] len);
        logic [16:0] one = 17'h1;
        return 16'((one << (len + 1)) - 17'h1);
    endfunction

    task automatic qwrite(input logic [2:0] a, input logic [29:0] v);
        @(negedge clk);
        q_we = 1'b1; q_addr = a;
        {q_cs, q_len, q_dly, q_tx} = v;
        @(negedge clk);
        q_we = 1'b0;
    endtask

    task automatic launch(input logic [2:0] s, input logic [2:0] e,
                          input logic [7:0] dv, input logic w);
        @(negedge clk);
        start_ptr = s; end_ptr = e; clk_div = dv; wrap_en = w;
        mon_clr = 1'b1;
        @(negedge clk);
        mon_clr = 1'b0; go = 1'b1;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic read_rx(input logic [2:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_rx;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] rv;
        logic [3:0]  ln;
        logic [7:0]  pd;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(cs_n == 4'hF, "R1 cs_n after reset", 32'(cs_n), 32'hF);
        chk(!sclk && !busy && !done, "R1 sclk/busy/done after reset",
            {sclk, busy, done}, 0);
        read_rx(3'd3, rv);
        chk(rv == 16'h0, "R1 receive slot after reset", 32'(rv), 0);

        // Table run: six entries, clk_div 4
        for (int i = 0; i < 6; i++) qwrite(3'(i), VEC[i]);
        launch(3'd0, 3'd5, 8'd4, 1'b0);
        wait_idle();
        chk(mon_n == 6, "R8 transfer count", 32'(mon_n), 6);
        chk(done && !busy, "R8 done after end entry", {done, busy}, 32'h2);
        for (int k = 0; k < 6; k++) begin
            ln = VEC[k][27:24];
            chk(rec_cs[k] == int'(VEC[k][29:28]), "R5 chip select index",
                32'(rec_cs[k]), 32'(VEC[k][29:28]));
            chk(rec_nb[k] == int'(ln) + 1, "R3 pulse count",
                32'(rec_nb[k]), 32'(ln) + 1);
            chk((rec_bits[k] & lmask(ln)) == (VEC[k][15:0] & lmask(ln)),
                "R3 mosi bits", 32'(rec_bits[k]), 32'(VEC[k][15:0] & lmask(ln)));
            chk(rec_lead[k] == 2, "R6 lead half-period",
                32'(rec_lead[k]), 2);
            if (k > 0) begin
                pd = VEC[k-1][23:16];
                chk(rec_gap[k] == 4 * int'(pd) + 1, "R7 gap length",
                    32'(rec_gap[k]), 32'(4 * int'(pd) + 1));
            end
            read_rx(3'(k), rv);
            chk(rv == (~VEC[k][15:0] & lmask(ln)), "R4 receive slot",
                32'(rv), 32'(~VEC[k][15:0] & lmask(ln)));
        end

        // Subset run with clk_div 2
        launch(3'd2, 3'd3, 8'd2, 1'b0);
        wait_idle();
        chk(mon_n == 2, "R8 subset count", 32'(mon_n), 2);
        chk(rec_cs[0] == 2 && rec_cs[1] == 3, "R8 subset order",
            32'(rec_cs[0] * 16 + rec_cs[1]), 32'h23);
        chk(rec_lead[0] == 1, "R6 lead at clk_div 2", 32'(rec_lead[0]), 1);
        chk(rec_gap[1] == 3, "R7 gap at clk_div 2", 32'(rec_gap[1]), 3);
        chk(done, "R8 done after subset", 32'(done), 1);

        // Halt mid-queue
        launch(3'd0, 3'd5, 8'd4, 1'b0);
        while (!cs_act) @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        wait_idle();
        chk(mon_n == 1, "R10 entries after halt", 32'(mon_n), 1);
        chk(!done && !busy, "R10 stopped without done", {done, busy}, 0);

        // Wrap run with writes during execution
        qwrite(3'd0, {2'd1, 4'd7, 8'd1, 16'h00A5});
        qwrite(3'd1, {2'd2, 4'd3, 8'd0, 16'h0009});
        launch(3'd0, 3'd1, 8'd4, 1'b1);
        while (mon_n < 2) @(negedge clk);
        while (!cs_act) @(negedge clk);
        chk(cur_ptr == 3'd0, "R9 wrapped to start", 32'(cur_ptr), 0);
        qwrite(3'd0, {2'd3, 4'd7, 8'd1, 16'h003C});
        qwrite(3'd1, {2'd2, 4'd3, 8'd0, 16'h0006});
        while (mon_n < 4) @(negedge clk);
        while (!cs_act) @(negedge clk);
        halt = 1'b1;
        @(negedge clk);
        halt = 1'b0;
        wait_idle();
        chk(mon_n == 5, "R9 transfers before halt", 32'(mon_n), 5);
        chk(rec_bits[2] == 16'h00A5 && rec_cs[2] == 1,
            "R11 running entry write ignored", 32'(rec_bits[2]), 32'h00A5);
        chk(rec_bits[4] == 16'h00A5 && rec_cs[4] == 1,
            "R11 ignored write stays ignored", 32'(rec_bits[4]), 32'h00A5);
        chk(rec_bits[3] == 16'h0006, "R11 other entry write accepted",
            32'(rec_bits[3]), 32'h0006);
        chk(!done, "R10 wrap halt leaves done low", 32'(done), 0);
        read_rx(3'd0, rv);
        chk(rv == 16'h005A, "R4 wrap receive entry 0", 32'(rv), 32'h5A);
        read_rx(3'd1, rv);
        chk(rv == 16'h0009, "R4 wrap receive entry 1", 32'(rv), 32'h9);

        // R1 idle outputs after everything
        chk(cs_n == 4'hF && !sclk, "R1 idle outputs", {cs_n, sclk}, 32'h1E);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule